// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block gathers 32 interrupt request lines and decides, for each one, whether it is pending. A pending source reaches any mix of four parent interrupt lines and any mix of four processor cores. Every source has its own trigger setting: level-high, level-low, rising edge or falling edge. Level sources pass through a two-stage synchronizer and then follow the input. Edge sources hold a sticky pending bit. Software clears that bit by masking the source.

Software reaches the block through a register port. A request is a valid/ready handshake. A read returns its data on a separate valid/ready response channel. The port accepts no new request while a read response waits unaccepted: `req_ready_o` is low whenever `rsp_valid_o` is high and `rsp_ready_i` is low. The response data stays unchanged until the response is accepted. A write produces no response.

Accesses are either a whole word or a single byte. In a byte access, `req_addr_i[1:0]` selects the byte lane. A byte write takes its data from `req_wdata_i[7:0]`. A byte read returns the lane's byte in `rsp_rdata_o[7:0]`, with the upper bits zero.

Top module: `rlic_top`

## Requirements
- R1: After reset, every register reads zero, every parent output is low and the pending status reads zero.
- R2: A write to 0x28 sets the mask bits that carry a one. A write to 0x2C clears the mask bits that carry a one. Zero bits leave the mask unchanged. A read of 0x24 returns the mask.
- R3: Offset 0x30 holds the per-source polarity (1 = high or rising) and offset 0x34 holds the per-source mode (1 = edge). Both are read/write, and both take byte writes and byte reads on the addressed lane.
- R4: A level source is active when the input matches its polarity bit. The change shows up two clock edges after the input changes, and not one edge after.
- R5: An edge source latches a pending bit on its active edge: a 0-to-1 transition when polarity is 1, a 1-to-0 transition when polarity is 0. The bit stays set after the input returns. The opposite transition sets nothing.
- R6: Writing a one for an edge source to 0x2C clears its latched pending bit. Enabling the source again afterwards does not bring the bit back.
- R7: A read of 0x40 returns the pending sources ANDed with the mask.
- R8: The route byte of source n sits at byte offset n (0x00 to 0x1F), stored little-endian within each word. A word read of offset 4m returns the route bytes of sources 4m to 4m+3.
- R9: Parent output k is high exactly when some enabled, pending source has bit 4+k set in its route byte.
- R10: A read of 0x44+4c (c = 0..3) returns the enabled pending sources whose route byte has bit c set.
- R11: A request is accepted on a clock edge where both `req_valid_i` and `req_ready_o` are high. While a read response is held back, `req_ready_o` stays low and the response data stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Interrupt source lines |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_word_i | input | 1 | 1 = word access, 0 = byte access |
| req_addr_i | input | 8 | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_ready_i | input | 1 | Read response ready |
| rsp_rdata_o | output | 32 | Read response data |
| parent_irq_o | output | 4 | Parent interrupt lines |

## Verification
The bench drives a falling-edge source through a rising transition, which must leave its status unchanged. A design with swapped edge polarity would latch that transition at once. The bench checks a parent output one edge and then two edges after an input change, which catches a synchronizer one stage short or one stage long. It masks and then re-enables a latched edge source; a design that clears only the mask would show the stale pending bit again. The bench also holds back a read response and checks that a design ignoring back-pressure neither takes a new request nor corrupts the held data, and it uses byte-lane writes to catch misplaced lane shifts in the route and polarity registers.

// File: rtl/rlic_pkg.sv
package rlic_pkg;
  localparam int unsigned SRC_N  = 32;
  localparam int unsigned PAR_N  = 4;
  localparam int unsigned CORE_N = 4;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  // word indices (byte offset >> 2)
  localparam logic [5:0] W_ENSTAT = 6'd9;   // 0x24
  localparam logic [5:0] W_EN     = 6'd10;  // 0x28
  localparam logic [5:0] W_DIS    = 6'd11;  // 0x2C
  localparam logic [5:0] W_POL    = 6'd12;  // 0x30
  localparam logic [5:0] W_EDGE   = 6'd13;  // 0x34
  localparam logic [5:0] W_STAT   = 6'd16;  // 0x40
  localparam logic [5:0] W_CORE0  = 6'd17;  // 0x44
endpackage

// File: rtl/rlic_regs.sv
module rlic_regs
  import rlic_pkg::*;
#(
  parameter int unsigned NSRC  = SRC_N,
  parameter int unsigned NCORE = CORE_N,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned IW    = ADDR_W - 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en_i,
  input  logic [IW-1:0]               idx_i,
  input  logic [DW-1:0]               wmask_i,
  input  logic [DW-1:0]               wval_i,
  input  logic [NSRC-1:0]             status_i,
  input  logic [NCORE-1:0][NSRC-1:0]  core_view_i,
  output logic [NSRC-1:0][7:0]        route_o,
  output logic [NSRC-1:0]             en_o,
  output logic [NSRC-1:0]             pol_o,
  output logic [NSRC-1:0]             edge_o,
  output logic [NSRC-1:0]             clr_o,
  output logic [DW-1:0]               rd_word_o
);
  localparam int unsigned NRW = NSRC / 4;
  localparam int unsigned RWW = $clog2(NRW);
  localparam int unsigned CW  = $clog2(NCORE);

  logic [NSRC-1:0] wbits;
  logic [NSRC-1:0] pmask;
  logic [IW-1:0]   cidx;

  assign wbits = wval_i[NSRC-1:0] & wmask_i[NSRC-1:0];
  assign pmask = wmask_i[NSRC-1:0];
  assign cidx  = idx_i - W_CORE0;
  assign clr_o = (wr_en_i && idx_i == W_DIS) ? wbits : '0;

  for (genvar s = 0; s < NSRC; s++) begin : g_route
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        route_o[s] <= '0;
      else if (wr_en_i && idx_i == IW'(s / 4) && wmask_i[(s % 4) * 8])
        route_o[s] <= wval_i[(s % 4) * 8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o   <= '0;
      pol_o  <= '0;
      edge_o <= '0;
    end else if (wr_en_i) begin
      case (idx_i)
        W_EN:    en_o   <= en_o | wbits;
        W_DIS:   en_o   <= en_o & ~wbits;
        W_POL:   pol_o  <= (pol_o & ~pmask) | wbits;
        W_EDGE:  edge_o <= (edge_o & ~pmask) | wbits;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_word_o = '0;
    if (idx_i < IW'(NRW)) begin
      rd_word_o = route_o[{idx_i[RWW-1:0], 2'b00} +: 4];
    end else begin
      case (idx_i)
        W_ENSTAT: rd_word_o = DW'(en_o);
        W_POL:    rd_word_o = DW'(pol_o);
        W_EDGE:   rd_word_o = DW'(edge_o);
        W_STAT:   rd_word_o = DW'(status_i);
        default:
          if (idx_i >= W_CORE0 && cidx < IW'(NCORE))
            rd_word_o = DW'(core_view_i[cidx[CW-1:0]]);
      endcase
    end
  end

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && idx_i == W_EN) |=> ((en_o & $past(wbits)) == $past(wbits)));

  // R2
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && idx_i == W_DIS) |=> ((en_o & $past(wbits)) == '0));
endmodule

// File: rtl/rlic_detect.sv
module rlic_detect
  import rlic_pkg::*;
#(
  parameter int unsigned NSRC = SRC_N
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] pol_i,
  input  logic [NSRC-1:0] edge_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] sync1, sync2, prev, latch_q;
  logic [NSRC-1:0] lvl_act, evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= '0;
      sync2   <= '0;
      prev    <= '0;
      latch_q <= '0;
    end else begin
      sync1   <= src_i;
      sync2   <= sync1;
      prev    <= sync2;
      latch_q <= edge_i & ~clr_i & (latch_q | evt);
    end
  end

  assign lvl_act = ~(sync2 ^ pol_i);
  assign evt     = edge_i & ((pol_i & sync2 & ~prev) | (~pol_i & ~sync2 & prev));
  assign pend_o  = (edge_i & latch_q) | (~edge_i & lvl_act);

  // R6
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> ((latch_q & $past(clr_i)) == '0));
endmodule

// File: rtl/rlic_route.sv
module rlic_route
  import rlic_pkg::*;
#(
  parameter int unsigned NSRC  = SRC_N,
  parameter int unsigned NPAR  = PAR_N,
  parameter int unsigned NCORE = CORE_N
) (
  input  logic [NSRC-1:0]             status_i,
  input  logic [NSRC-1:0][7:0]        route_i,
  output logic [NPAR-1:0]             parent_o,
  output logic [NCORE-1:0][NSRC-1:0]  core_view_o
);
  for (genvar k = 0; k < NPAR; k++) begin : g_par
    logic [NSRC-1:0] col;
    for (genvar s = 0; s < NSRC; s++) begin : g_s
      assign col[s] = route_i[s][4 + k];
    end
    assign parent_o[k] = |(status_i & col);
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic [NSRC-1:0] col;
    for (genvar s = 0; s < NSRC; s++) begin : g_s
      assign col[s] = route_i[s][c];
    end
    assign core_view_o[c] = status_i & col;
  end
endmodule

// File: rtl/rlic_top.sv
module rlic_top
  import rlic_pkg::*;
#(
  parameter int unsigned NSRC  = SRC_N,
  parameter int unsigned NPAR  = PAR_N,
  parameter int unsigned NCORE = CORE_N,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned DW    = DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_write_i,
  input  logic            req_word_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [DW-1:0]   req_wdata_i,
  output logic            rsp_valid_o,
  input  logic            rsp_ready_i,
  output logic [DW-1:0]   rsp_rdata_o,
  output logic [NPAR-1:0] parent_irq_o
);
  localparam int unsigned IW = AW - 2;

  logic                       fire;
  logic [1:0]                 lane;
  logic [4:0]                 lsh;
  logic [DW-1:0]              wmask, wval, rd_word, rd_sel;
  logic [NSRC-1:0][7:0]       route;
  logic [NSRC-1:0]            en, pol, edge_m, clr, pend, status;
  logic [NCORE-1:0][NSRC-1:0] core_view;

  assign req_ready_o = ~rsp_valid_o | rsp_ready_i;
  assign fire        = req_valid_i & req_ready_o;
  assign lane        = req_addr_i[1:0];
  assign lsh         = {lane, 3'b000};
  assign wmask       = req_word_i ? '1 : (DW'(8'hFF) << lsh);
  assign wval        = req_word_i ? req_wdata_i : {(DW / 8){req_wdata_i[7:0]}};
  assign rd_sel      = req_word_i ? rd_word : ((rd_word >> lsh) & DW'(8'hFF));
  assign status      = pend & en;

  rlic_regs #(.NSRC(NSRC), .NCORE(NCORE), .DW(DW), .IW(IW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (fire & req_write_i),
    .idx_i       (req_addr_i[AW-1:2]),
    .wmask_i     (wmask),
    .wval_i      (wval),
    .status_i    (status),
    .core_view_i (core_view),
    .route_o     (route),
    .en_o        (en),
    .pol_o       (pol),
    .edge_o      (edge_m),
    .clr_o       (clr),
    .rd_word_o   (rd_word)
  );

  rlic_detect #(.NSRC(NSRC)) u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_i),
    .pol_i  (pol),
    .edge_i (edge_m),
    .clr_i  (clr),
    .pend_o (pend)
  );

  rlic_route #(.NSRC(NSRC), .NPAR(NPAR), .NCORE(NCORE)) u_route (
    .status_i    (status),
    .route_i     (route),
    .parent_o    (parent_irq_o),
    .core_view_o (core_view)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else if (fire && !req_write_i) begin
      rsp_valid_o <= 1'b1;
      rsp_rdata_o <= rd_sel;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_rdata_o)));

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> (parent_irq_o == '0));
endmodule

// File: tb/test_rlic_top.sv
module test_rlic_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b1;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [3:0]  parent;

  int nchk = 0, nerr = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  rlic_top i_rlic_top (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_word_i(req_word), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .parent_irq_o(parent)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: each negedge with valid&ready precedes a unique transfer
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk(rsp_rdata, 32'hDEAD_BEEF, "R11 unexpected response");
      else chk(rsp_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic bus(input logic wr, input logic word, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_word = word; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic word = 1'b1);
    bus(1'b1, word, a, d);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag, input logic word = 1'b1);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus(1'b0, word, a, 32'h0);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({28'h0, parent}, 32'h0, "R1 parent after reset");
    rd(8'h24, 32'h0, "R1 mask");
    rd(8'h30, 32'h0, "R1 polarity");
    rd(8'h34, 32'h0, "R1 mode");
    rd(8'h40, 32'h0, "R1 status");
    rd(8'h00, 32'h0, "R1 route");

    // R8 route bytes
    wr(8'h00, 32'h8844_2112);
    rd(8'h00, 32'h8844_2112, "R8 word read");
    rd(8'h02, 32'h0000_0044, "R8 byte read", 1'b0);
    wr(8'h05, 32'h0000_0084, 1'b0);
    rd(8'h04, 32'h0000_8400, "R8 byte write lane");

    // R2 mask set/clear, R7 status
    wr(8'h28, 32'h0000_FF00);
    wr(8'h2C, 32'h0000_0F00);
    rd(8'h24, 32'h0000_F000, "R2 set then clear");
    wr(8'h29, 32'h0000_0001, 1'b0);
    rd(8'h24, 32'h0000_F100, "R2 byte set");
    settle();
    rd(8'h40, 32'h0000_F100, "R7 level-low pending masked");
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h24, 32'h0, "R2 clear all");
    rd(8'h40, 32'h0, "R7 all masked");

    // R3 polarity / mode
    wr(8'h30, 32'h5);
    wr(8'h34, 32'hC);
    wr(8'h31, 32'h0000_00A5, 1'b0);
    rd(8'h30, 32'h0000_A505, "R3 polarity byte write");
    rd(8'h31, 32'h0000_00A5, "R3 polarity byte read", 1'b0);
    rd(8'h34, 32'h0000_000C, "R3 mode");

    // R4 level sources
    wr(8'h28, 32'hF);
    settle();
    rd(8'h40, 32'h2, "R4 level-low active at 0");
    chk({28'h0, parent}, 32'h2, "R9 parent1");
    rd(8'h44, 32'h2, "R10 core0 view");
    rd(8'h48, 32'h0, "R10 core1 view empty");
    @(negedge clk);
    src[0] = 1'b1;
    @(negedge clk);
    chk({28'h0, parent}, 32'h2, "R4 not yet after one edge");
    @(negedge clk);
    chk({28'h0, parent}, 32'h3, "R4 visible after two edges");
    rd(8'h40, 32'h3, "R4 level-high");
    rd(8'h48, 32'h1, "R10 core1 view");
    src[1] = 1'b1;
    settle();
    rd(8'h40, 32'h1, "R4 level-low released");

    // R5 edges
    src[2] = 1'b1; settle(); src[2] = 1'b0; settle();
    rd(8'h40, 32'h5, "R5 rising latched");
    chk({28'h0, parent}, 32'h5, "R9 parents 0,2");
    rd(8'h4C, 32'h4, "R10 core2 view");
    src[3] = 1'b1; settle();
    rd(8'h40, 32'h5, "R5 wrong-direction edge ignored");
    src[3] = 1'b0; settle();
    rd(8'h40, 32'hD, "R5 falling latched");
    chk({28'h0, parent}, 32'hD, "R9 parents 0,2,3");
    rd(8'h50, 32'h8, "R10 core3 view");

    // R6 clear via disable
    wr(8'h2C, 32'h4);
    rd(8'h40, 32'h9, "R6 masked");
    wr(8'h28, 32'h4);
    rd(8'h40, 32'h9, "R6 latch gone after re-enable");
    rd(8'h24, 32'hF, "R6 mask restored");
    chk({28'h0, parent}, 32'h9, "R9 parents 0,3");

    // R11 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    rd(8'h40, 32'h9, "R11 held response");
    held = rsp_rdata;
    for (int i = 0; i < 3; i++) begin
      chk({31'h0, req_ready}, 32'h0, "R11 ready low while held");
      chk(rsp_rdata, held, "R11 data stable");
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);

    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h40, 32'h0, "R7 status after mask all");
    @(negedge clk);
    chk({28'h0, parent}, 32'h0, "R9 parents low");
    repeat (3) @(negedge clk);
    chk(exp_q.size(), 32'h0, "R11 all responses seen");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule